// File: doc/BRIEF.md
# Sign-Gated Two-Axis Dither Source

This block supplies a small, zero-centred perturbation for each of the two axes of a space-vector sigma-delta modulator. The two axes use a 60-degree coordinate frame. For every accepted sample it draws one new pseudo-random word per axis and subtracts half of its full scale, so the value is centred on zero. It then scales the result to a few least significant bits of the modulator's input word.

A sign check follows, separately for each axis. It compares the sign of that axis's reference, which is the modulator input, with the sign of that axis's feedback, which is the modulator output. When the two signs disagree, the dither for that axis is forced to zero for that sample. This keeps the switching rate from collapsing. A value of zero counts as non-negative.

Samples enter on a valid/ready handshake, and the dither words leave on a second valid/ready handshake. There is a single output register between them. A sample is accepted only while the output register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input, and it also freezes both random sources.

Top module: `sdd_dither_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A sample accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on `dith_m`/`dith_n` with `out_valid` = 1 right after that same edge. `out_valid` drops after an edge with `out_ready` = 1 and no new acceptance.
- R3: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and `out_valid`, `dith_m` and `dith_n` hold their values.
- R4: Each axis has its own 16-bit Galois LFSR. At each step it shifts right, and when the bit shifted out is 1 it XORs the mask 0xB400. The seeds are 0xACE1 for the m axis and 0x1D2B for the n axis. Each LFSR advances exactly once per accepted sample and never otherwise. The first sample after reset uses the seed.
- R5: The ungated dither is computed from the current LFSR state. Its bits [15:12], read as an unsigned number, have 8 subtracted. The result is shifted left by `DITHER_SHIFT` (default 0) and sign-extended to 12 bits, so by default it lies in -8..7.
- R6: For each axis, if the reference (signed, 12 bits) and the feedback (signed, 3 bits) have different signs, that axis's dither word is 0. Zero counts as non-negative.
- R7: The two axes are gated and randomised independently. Gating one axis leaves the other axis's value and sequence unchanged.
- R8: Over 4096 consecutive ungated samples, the mean of each axis's dither lies within ±1 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe / input valid |
| in_ready | output | 1 | Block can take a sample |
| ref_m | input | 12 | Reference, m axis (signed) |
| ref_n | input | 12 | Reference, n axis (signed) |
| fb_m | input | 3 | Quantizer feedback, m axis (signed) |
| fb_n | input | 3 | Quantizer feedback, n axis (signed) |
| out_valid | output | 1 | Dither words valid |
| out_ready | input | 1 | Consumer takes dither words |
| dith_m | output | 12 | Dither, m axis (signed) |
| dith_n | output | 12 | Dither, n axis (signed) |

## Verification
Every dither result is due one clock edge after its sample is accepted, because a single output register stands between input and output. The bench therefore drives each sample at a falling edge. It then compares `dith_m`, `dith_n` and `out_valid` at the next falling edge against a bench-side LFSR model that advances only when a sample was accepted. During output stalls, the bench checks at each falling edge that `in_ready` is low and the words are frozen. It also confirms that the model did not advance when the stall is released.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int NUM_AXES = 2;
  localparam int AXIS_M = 0;
  localparam int AXIS_N = 1;

  // Galois right-shift step of a generic-width LFSR
  function automatic logic [31:0] galois_step(input logic [31:0] s, input logic [31:0] mask);
    logic [31:0] nxt;
    nxt = s >> 1;
    if (s[0]) nxt = nxt ^ mask;
    return nxt;
  endfunction
endpackage

// File: rtl/sdd_lfsr.sv
module sdd_lfsr #(
  parameter int          W    = 16,
  parameter logic [31:0] MASK = 32'h0000_B400,
  parameter logic [31:0] SEED = 32'h0000_ACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  import sdd_pkg::*;

  logic [31:0] widened;
  logic [31:0] stepped;

  assign widened = 32'(state);
  assign stepped = galois_step(widened, MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED[W-1:0];
    else if (step) state <= stepped[W-1:0];
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R4
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state)); // R4
  AST_LFSR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != $past(state)); // R4
endmodule

// File: rtl/sdd_sign_gate.sv
module sdd_sign_gate #(
  parameter int REF_W = 12,
  parameter int FB_W  = 3,
  parameter int RND_W = 4,
  parameter int SHIFT = 0,
  parameter int OUT_W = 12
) (
  input  logic [RND_W-1:0]        rnd,
  input  logic signed [REF_W-1:0] ref_val,
  input  logic signed [FB_W-1:0]  fb_val,
  output logic signed [OUT_W-1:0] dither
);
  localparam int HALF = 1 << (RND_W - 1);

  logic signed [RND_W:0]   centred;
  logic signed [OUT_W-1:0] widened;
  logic                    ref_neg;
  logic                    fb_neg;

  assign centred = $signed({1'b0, rnd}) - $signed((RND_W+1)'(HALF));
  assign widened = OUT_W'(centred) <<< SHIFT;
  assign ref_neg = (ref_val < 0);
  assign fb_neg  = (fb_val < 0);
  assign dither  = (ref_neg != fb_neg) ? '0 : widened;

  initial begin
    assert (OUT_W >= RND_W + 1 + SHIFT) else $error("dither does not fit output width");
  end
endmodule

// File: rtl/sdd_dither_top.sv
module sdd_dither_top #(
  parameter int          REF_W        = 12,
  parameter int          FB_W         = 3,
  parameter int          LFSR_W       = 16,
  parameter logic [31:0] LFSR_MASK    = 32'h0000_B400,
  parameter logic [31:0] SEED_M       = 32'h0000_ACE1,
  parameter logic [31:0] SEED_N       = 32'h0000_1D2B,
  parameter int          DITHER_W     = 4,
  parameter int          DITHER_SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [REF_W-1:0] ref_m,
  input  logic signed [REF_W-1:0] ref_n,
  input  logic signed [FB_W-1:0]  fb_m,
  input  logic signed [FB_W-1:0]  fb_n,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [REF_W-1:0] dith_m,
  output logic signed [REF_W-1:0] dith_n
);
  import sdd_pkg::*;

  localparam int OUT_W  = REF_W;
  localparam int PEAK   = (1 << (DITHER_W - 1)) << DITHER_SHIFT;

  logic                    accept;
  logic signed [REF_W-1:0] ref_a  [NUM_AXES];
  logic signed [FB_W-1:0]  fb_a   [NUM_AXES];
  logic signed [OUT_W-1:0] dnext  [NUM_AXES];
  logic signed [OUT_W-1:0] dreg   [NUM_AXES];

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  assign ref_a[AXIS_M] = ref_m;
  assign ref_a[AXIS_N] = ref_n;
  assign fb_a[AXIS_M]  = fb_m;
  assign fb_a[AXIS_N]  = fb_n;

  for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
    logic [LFSR_W-1:0] st;

    sdd_lfsr #(
      .W    (LFSR_W),
      .MASK (LFSR_MASK),
      .SEED ((ax == AXIS_M) ? SEED_M : SEED_N)
    ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept),
      .state (st)
    );

    sdd_sign_gate #(
      .REF_W (REF_W),
      .FB_W  (FB_W),
      .RND_W (DITHER_W),
      .SHIFT (DITHER_SHIFT),
      .OUT_W (OUT_W)
    ) u_gate (
      .rnd     (st[LFSR_W-1 -: DITHER_W]),
      .ref_val (ref_a[ax]),
      .fb_val  (fb_a[ax]),
      .dither  (dnext[ax])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)      dreg[ax] <= '0;
      else if (accept) dreg[ax] <= dnext[ax];
    end

    AST_GATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ((ref_a[ax] < 0) != (fb_a[ax] < 0))) |=> dreg[ax] == 0); // R6
    AST_DITHER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (dreg[ax] >= -PEAK) && (dreg[ax] < PEAK)); // R5
  end

  // Low bits of the unused LFSR word lie outside the dither window by design.
  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (accept)    out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  assign dith_m = dreg[AXIS_M];
  assign dith_n = dreg[AXIS_N];

  AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(dith_m) && $stable(dith_n)); // R3
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> $stable(dith_m) && $stable(dith_n)); // R3
endmodule

// File: tb/sim_sdd_dither_top.sv
module sim_sdd_dither_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [11:0] ref_m = '0, ref_n = '0;
  logic signed [2:0]  fb_m = '0, fb_n = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [11:0] dith_m, dith_n;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] sm = 16'hACE1;
  logic [15:0] sn = 16'h1D2B;

  always #2.5 clk = ~clk;

  sdd_dither_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ref_m(ref_m), .ref_n(ref_n), .fb_m(fb_m), .fb_n(fb_n),
    .out_valid(out_valid), .out_ready(out_ready),
    .dith_m(dith_m), .dith_n(dith_n)
  );

  function automatic logic [15:0] step16(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic int raw_of(input logic [15:0] s);
    return int'(s[15:12]) - 8;
  endfunction

  function automatic int gated(input logic [15:0] s, input int r, input int f);
    return ((r < 0) != (f < 0)) ? 0 : raw_of(s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one accepted sample with out_ready high; checks R2/R4/R5/R6/R7
  task automatic send(input int rm, input int rn, input int fm, input int fn,
                      input string req, output int got_m, output int got_n);
    @(negedge clk);
    ref_m = 12'(rm); ref_n = 12'(rn); fb_m = 3'(fm); fb_n = 3'(fn);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, int'(out_valid), 1);
    check({req, " m"}, int'(dith_m), gated(sm, rm, fm));
    check({req, " n"}, int'(dith_n), gated(sn, rn, fn));
    got_m = int'(dith_m); got_n = int'(dith_n);
    sm = step16(sm); sn = step16(sn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int rvals [5] = '{-2048, -1, 0, 1, 2047};
    int fvals [4] = '{-4, -1, 0, 3};
    int gm, gn;
    longint sum_m, sum_n;
    logic signed [11:0] hold_m, hold_n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);

    // R6/R7 sweep of all sign combinations on both axes
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 4; d++)
            send(rvals[a], rvals[c], fvals[b], fvals[d], "R6 sweep", gm, gn);

    // R2: drop of out_valid when no new sample
    @(negedge clk);
    check("R2 idle drop", int'(out_valid), 0);

    // R3: back-pressure stall
    @(negedge clk);
    ref_m = 12'sd5; ref_n = 12'sd7; fb_m = 3'sd1; fb_n = 3'sd1;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R3 first m", int'(dith_m), raw_of(sm));
    check("R3 first n", int'(dith_n), raw_of(sn));
    sm = step16(sm); sn = step16(sn);
    hold_m = dith_m; hold_n = dith_n;
    ref_m = -12'sd9; fb_m = 3'sd2;  // second sample offered, must wait
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 in_ready low", int'(in_ready), 0);
      check("R3 valid held", int'(out_valid), 1);
      check("R3 m held", int'(dith_m), int'(hold_m));
      check("R3 n held", int'(dith_n), int'(hold_n));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R4: LFSR advanced only once during the stall
    check("R4 after stall m gated", int'(dith_m), gated(sm, -9, 2));
    check("R4 after stall n", int'(dith_n), raw_of(sn));
    sm = step16(sm); sn = step16(sn);

    // R8: mean of ungated dither over 4096 samples (signs agree)
    sum_m = 0; sum_n = 0;
    for (int i = 0; i < 4096; i++) begin
      send(100 + (i % 50), -(1 + (i % 30)), i % 4, -1 - (i % 4), "R8 stream", gm, gn);
      sum_m += gm; sum_n += gn;
    end
    check("R8 mean m within 1 LSB", int'((sum_m >= -4096) && (sum_m <= 4096)), 1);
    check("R8 mean n within 1 LSB", int'((sum_n >= -4096) && (sum_n <= 4096)), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule